// File: doc/BRIEF.md
# Combined Enable/Pending Interrupt Aggregator

This block gathers a small set of interrupt sources, at most thirteen, and presents them to a parent interrupt controller as a single level-sensitive request. Each source input passes through a two-stage synchronizer. A rising edge on a source sets that source's pending flag, but only while the source is enabled. The output request is a registered OR of every flag that is both pending and enabled. It stays high for as long as any such pair remains.

In the default layout one 32-bit register holds both fields. The enable for a source sits at bit n and its pending flag sits sixteen places higher. Pending flags clear when a 1 is written to them, and a 0 leaves them unchanged. Enables are plain read/write bits that every write updates. Software can therefore change the enables without disturbing pending state by writing zeros into the upper half. A build option moves the two fields into separate registers at byte offsets 0x0 and 0x4. In that layout both fields use the same bit index, and a parameter picks which offset holds the enables. Further parameters set the number of sources and the bit position of the first one, and `FIRST_BIT + NUM_SRC` must not exceed 13.

Software is expected to bring the block up by writing all ones to the pending field and then writing zero to turn every source off.

Top module: `pend_irq_hub`

## Requirements
- R1: While `rst` is high at a clock edge, all enables, all pending flags and `irq_out` are cleared, and every register reads as zero.
- R2: In combined mode (SPLIT=0) the register at offset 0x0 reads back with the enable of source i at bit FIRST_BIT+i and its pending flag at bit FIRST_BIT+i+16.
- R3: Every write to the register holding the enables loads all enable bits in range from the write data. In combined mode these are the low-half bits.
- R4: A pending flag clears only when a 1 is written to its bit position. A write with 0 there, including an enable-only update in combined mode, leaves it unchanged.
- R5: A pending flag is set only by a rising edge of its source while that source is enabled. An edge seen while the source is disabled is lost. A source held high does not set the flag again after it has been cleared.
- R6: When a flag-setting edge and a write-1-to-clear of the same flag land in the same clock cycle, the flag ends up set.
- R7: Bits outside FIRST_BIT..FIRST_BIT+NUM_SRC-1 in both fields read as zero and ignore writes. In combined mode this includes bits 31:29 and 15:13.
- R8: `irq_out` is high one clock after any enabled source is pending, and it stays high while that holds. It is low one clock after no enabled pending flag remains, so masking a pending source drops the request.
- R9: In split mode (SPLIT=1) the enables and the write-1-to-clear pending flags sit at the same bit index in separate registers. The enables are at byte offset EN_OFS and the pending flags at EN_OFS XOR 0x4, each read in bits 15:0.
- R10: Source input i maps to bit FIRST_BIT+i, so a nonzero FIRST_BIT shifts both fields up.
- R11: Addresses that hold no register read as zero, and writes to them change nothing.
- R12: Writing 0x1FFF0000 and then 0x00000000 to the combined register leaves every flag clear, every source disabled and `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Asynchronous interrupt sources |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Level interrupt request to the parent |

## Verification
Four properties are checked on every cycle: pending flags stay set unless a clear mask arrives, no flag appears on a source that was disabled, a set beats a same-cycle clear, and out-of-range bits stay zero. The request is also checked on every cycle to follow the enabled-pending condition with one clock of lag. The following can only be shown through bench scenarios: the combined bit layout seen at the port, the offset swap in split mode, the shift from a nonzero first bit, decoding of unmapped addresses, the bring-up sequence, and the fact that a source held high sets its flag only once.

// File: rtl/pend_irq_pkg.sv
package pend_irq_pkg;

    localparam int REG_W    = 32;
    localparam int HALF_W   = 16;
    localparam int MAX_SRC  = 13;
    localparam int ALT_OFS  = 4;

    typedef logic [HALF_W-1:0] bitvec_t;
    typedef logic [REG_W-1:0]  word_t;

    // Write command produced by the register decoder for the flag bank.
    typedef struct packed {
        logic    en_we;
        bitvec_t en_wdata;
        bitvec_t clr;
    } wr_cmd_t;

    function automatic bitvec_t used_mask(input int first, input int count);
        bitvec_t m;
        m = '0;
        for (int b = 0; b < HALF_W; b++) begin
            if (b >= first && b < first + count) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pend_sync.sv
module pend_sync
    import pend_irq_pkg::*;
#(
    parameter int NUM_SRC   = 7,
    parameter int FIRST_BIT = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    output bitvec_t            rise
);

    logic [NUM_SRC-1:0] rise_n;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // [0],[1] synchronizer stages, [2] previous synchronized value
        logic [2:0] stage;
        always_ff @(posedge clk) begin
            if (rst) stage <= '0;
            else     stage <= {stage[1:0], src_in[i]};
        end
        assign rise_n[i] = stage[1] & ~stage[2];
    end

    always_comb begin
        rise = HALF_W'(rise_n) << FIRST_BIT;
    end

endmodule

// File: rtl/pend_regport.sv
module pend_regport
    import pend_irq_pkg::*;
#(
    parameter int NUM_SRC   = 7,
    parameter int FIRST_BIT = 0,
    parameter bit SPLIT     = 1'b0,
    parameter int ADDR_W    = 3,
    parameter int EN_OFS    = 0
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  word_t             reg_wdata,
    input  bitvec_t           en,
    input  bitvec_t           pend,
    output wr_cmd_t           cmd,
    output word_t             reg_rdata
);

    localparam bitvec_t USED = used_mask(FIRST_BIT, NUM_SRC);
    localparam int EN_A_I = SPLIT ? EN_OFS : 0;
    localparam int PD_A_I = SPLIT ? (EN_OFS ^ ALT_OFS) : 0;
    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_A_I);
    localparam logic [ADDR_W-1:0] PD_A = ADDR_W'(PD_A_I);

    logic hit_en, hit_pd;
    assign hit_en = (reg_addr == EN_A);
    assign hit_pd = (reg_addr == PD_A);

    always_comb begin
        cmd       = '0;
        reg_rdata = '0;
        if (!SPLIT) begin
            if (hit_en) begin
                reg_rdata = {pend, en};
                if (reg_we) begin
                    cmd.en_we    = 1'b1;
                    cmd.en_wdata = reg_wdata[HALF_W-1:0] & USED;
                    cmd.clr      = reg_wdata[REG_W-1:HALF_W] & USED;
                end
            end
        end else begin
            if (hit_en) begin
                reg_rdata = {{HALF_W{1'b0}}, en};
                if (reg_we) begin
                    cmd.en_we    = 1'b1;
                    cmd.en_wdata = reg_wdata[HALF_W-1:0] & USED;
                end
            end
            if (hit_pd) begin
                reg_rdata = {{HALF_W{1'b0}}, pend};
                if (reg_we) cmd.clr = reg_wdata[HALF_W-1:0] & USED;
            end
        end
    end

endmodule

// File: rtl/pend_bank.sv
module pend_bank
    import pend_irq_pkg::*;
#(
    parameter int NUM_SRC   = 7,
    parameter int FIRST_BIT = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  bitvec_t rise,
    input  wr_cmd_t cmd,
    output bitvec_t en,
    output bitvec_t pend
);

    localparam bitvec_t USED = used_mask(FIRST_BIT, NUM_SRC);

    bitvec_t set_vec;
    assign set_vec = rise & en & USED;

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= '0;
            pend <= '0;
        end else begin
            if (cmd.en_we) en <= cmd.en_wdata;
            pend <= (pend & ~cmd.clr) | set_vec;
        end
    end

    assert_rst_clears_R1: assert property (@(posedge clk)
        rst |=> (en == '0 && pend == '0));

    assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr == '0) |=> ((pend & $past(pend)) == $past(pend)));

    assert_no_set_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        (en == '0 && pend == '0 && cmd.en_we == 1'b0) |=> (pend == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (|(rise & en)) |=> ((pend & $past(rise & en)) == $past(rise & en)));

    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ((en | pend) & ~USED) == '0);

endmodule

// File: rtl/pend_irq_hub.sv
module pend_irq_hub
    import pend_irq_pkg::*;
#(
    parameter int NUM_SRC   = 7,
    parameter int FIRST_BIT = 0,
    parameter bit SPLIT     = 1'b0,
    parameter int ADDR_W    = 3,
    parameter int EN_OFS    = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_out
);

    bitvec_t rise, en, pend;
    wr_cmd_t cmd;

    pend_sync #(.NUM_SRC(NUM_SRC), .FIRST_BIT(FIRST_BIT)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .src_in (src_in),
        .rise   (rise)
    );

    pend_regport #(
        .NUM_SRC(NUM_SRC), .FIRST_BIT(FIRST_BIT), .SPLIT(SPLIT),
        .ADDR_W(ADDR_W), .EN_OFS(EN_OFS)
    ) u_port (
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .en        (en),
        .pend      (pend),
        .cmd       (cmd),
        .reg_rdata (reg_rdata)
    );

    pend_bank #(.NUM_SRC(NUM_SRC), .FIRST_BIT(FIRST_BIT)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .cmd  (cmd),
        .en   (en),
        .pend (pend)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= |(pend & en);
    end

    assert_irq_rises_R8: assert property (@(posedge clk) disable iff (rst)
        (|(pend & en)) |=> irq_out);

    assert_irq_falls_R8: assert property (@(posedge clk) disable iff (rst)
        !(|(pend & en)) |=> !irq_out);

endmodule

// File: tb/sim_pend_irq_hub.sv
`timescale 1ns/1ps
module sim_pend_irq_hub;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [6:0]  src0 = '0;
    logic [2:0]  addr0 = '0;
    logic        we0 = 1'b0;
    logic [31:0] wd0 = '0;
    logic [31:0] rd0;
    logic        irq0;

    logic [1:0]  src1 = '0;
    logic [2:0]  addr1 = '0;
    logic        we1 = 1'b0;
    logic [31:0] wd1 = '0;
    logic [31:0] rd1;
    logic        irq1;

    pend_irq_hub #(.NUM_SRC(7), .FIRST_BIT(0), .SPLIT(1'b0)) u0 (
        .clk(clk), .rst(rst), .src_in(src0), .reg_addr(addr0), .reg_we(we0),
        .reg_wdata(wd0), .reg_rdata(rd0), .irq_out(irq0)
    );

    pend_irq_hub #(.NUM_SRC(2), .FIRST_BIT(4), .SPLIT(1'b1), .EN_OFS(4)) u1 (
        .clk(clk), .rst(rst), .src_in(src1), .reg_addr(addr1), .reg_we(we1),
        .reg_wdata(wd1), .reg_rdata(rd1), .irq_out(irq1)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr0(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); addr0 = a; we0 = 1'b1; wd0 = d;
        @(negedge clk); we0 = 1'b0; wd0 = '0;
    endtask

    task automatic wr1(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); addr1 = a; we1 = 1'b1; wd1 = d;
        @(negedge clk); we1 = 1'b0; wd1 = '0;
    endtask

    task automatic rdr0(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); addr0 = a; #1 d = rd0;
    endtask

    task automatic rdr1(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); addr1 = a; #1 d = rd1;
    endtask

    task automatic pulse0(input logic [6:0] m);
        @(negedge clk); src0 = m;
        repeat (3) @(negedge clk);
        src0 = '0;
        repeat (3) @(negedge clk);
    endtask

    typedef struct packed {
        logic [6:0]  pulse;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        irq;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{7'h00, 32'h0000_007F, 32'h0000_007F, 1'b0},
        '{7'h05, 32'h0000_007F, 32'h0005_007F, 1'b1},
        '{7'h02, 32'h0001_007F, 32'h0006_007F, 1'b1},
        '{7'h00, 32'hFFFF_FFFF, 32'h0000_007F, 1'b0},
        '{7'h40, 32'h0000_0000, 32'h0040_0000, 1'b0},
        '{7'h01, 32'h0000_0040, 32'h0040_0040, 1'b1},
        '{7'h00, 32'h0000_FF80, 32'h0040_0000, 1'b0},
        '{7'h00, 32'h1FFF_0000, 32'h0000_0000, 1'b0}
    };

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        rdr0(3'd0, v); check("R1 combined reg after reset", v, 32'h0);
        check("R1 irq after reset", {31'b0, irq0}, 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        rdr1(3'd4, v); check("R1 split enable after reset", v, 32'h0);

        // R12: bring-up sequence
        wr0(3'd0, 32'h1FFF_0000);
        wr0(3'd0, 32'h0000_0000);
        rdr0(3'd0, v); check("R12 after bring-up", v, 32'h0);
        check("R12 irq after bring-up", {31'b0, irq0}, 32'h0);

        // Table: R2 R3 R4 R5 R7 R8
        for (int k = 0; k < 8; k++) begin
            pulse0(VEC[k].pulse);
            wr0(3'd0, VEC[k].wd);
            repeat (2) @(negedge clk);
            rdr0(3'd0, v);
            check($sformatf("R2/R3/R4/R7 vector %0d readback", k), v, VEC[k].exp);
            check($sformatf("R8/R5 vector %0d irq", k), {31'b0, irq0}, {31'b0, VEC[k].irq});
        end

        // R8: request holds while pending remains
        wr0(3'd0, 32'h0000_0001);
        pulse0(7'h01);
        repeat (10) @(negedge clk);
        check("R8 irq held while pending", {31'b0, irq0}, 32'h1);

        // R6: set and clear in the same cycle, set wins
        @(negedge clk); src0 = 7'h01;          // edge k samples it
        @(negedge clk);                        // after k
        @(negedge clk);                        // after k+1: rise is active now
        addr0 = 3'd0; we0 = 1'b1; wd0 = 32'h0001_0001;
        @(negedge clk); we0 = 1'b0; wd0 = '0;  // clear applied at k+2 with set
        rdr0(3'd0, v); check("R6 set beats clear", v, 32'h0001_0001);

        // R5: level held high does not re-set after clear
        wr0(3'd0, 32'h0001_0001);
        repeat (4) @(negedge clk);
        rdr0(3'd0, v); check("R5 held level no re-set", v, 32'h0000_0001);
        check("R8 irq low after clear", {31'b0, irq0}, 32'h0);
        src0 = '0;
        repeat (3) @(negedge clk);

        // R11: unmapped address in combined mode
        wr0(3'd4, 32'hFFFF_FFFF);
        rdr0(3'd4, v); check("R11 unmapped reads zero", v, 32'h0);
        rdr0(3'd0, v); check("R11 unmapped write ignored", v, 32'h0000_0001);

        // R9 R10 R7: split instance, enables at 0x4, pending at 0x0, first bit 4
        wr1(3'd4, 32'hFFFF_FFFF);
        rdr1(3'd4, v); check("R9/R10/R7 split enable readback", v, 32'h0000_0030);
        @(negedge clk); src1 = 2'b10;
        repeat (3) @(negedge clk); src1 = 2'b00;
        repeat (3) @(negedge clk);
        rdr1(3'd0, v); check("R9/R10 split pending bit5", v, 32'h0000_0020);
        check("R9 split irq", {31'b0, irq1}, 32'h1);
        wr1(3'd0, 32'h0000_0010);
        rdr1(3'd0, v); check("R4 split other bit clear no effect", v, 32'h0000_0020);
        wr1(3'd0, 32'h0000_0020);
        repeat (2) @(negedge clk);
        rdr1(3'd0, v); check("R9 split pending cleared", v, 32'h0);
        check("R9 split irq low", {31'b0, irq1}, 32'h0);
        rdr1(3'd4, v); check("R3 split enables kept", v, 32'h0000_0030);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule